// File: doc/BRIEF.md
# Encoder Interface Clock Generator

This block produces the clock that is driven out to an external position encoder. After reset the output rests high and stays still. A go strobe starts it. While it runs, the output changes level once for every `HALF_DIV` cycles in which the divider enable input is high. A 2-bit mode register sets the stop policy. The clock can stop low or high once the receiver reports a complete frame. It can stop high once the transmitter reports that its last bit is on the wire. It can also run freely with no stop at all.

A stop request is held pending until the output edge that brings the clock to the required stop level. The clock freezes on that edge. Every phase that is driven therefore has full length. The `running_o` flag is high while the clock is active. The serializer and the receiver use it to qualify their bit strobes.

Free-run mode locks the mode register. The only way out is a reinit. Reinit stops the clock, returns it high and restores the stop-high-after-receive mode. All pins are plain control and status pins. The block has no data stream, so no valid/ready handshake applies.

Top module: `enc_clk_ctrl`

## Requirements
- R1: After reset, `enc_clk_o` is 1, `running_o` is 0 and the mode is 1 (stop high after receive done).
- R2: While not running, `enc_clk_o` holds its level whatever `rx_done_i`, `tx_last_done_i` and `div_en_i` do.
- R3: A `go_i` accepted while not running raises `running_o` on the next edge. The first output edge follows `HALF_DIV` later edges with `div_en_i` high.
- R4: While running, `enc_clk_o` toggles only after exactly `HALF_DIV` edges with `div_en_i` high. It holds while `div_en_i` is low.
- R5: Mode 0: after `rx_done_i`, the clock stops at the next toggle that drives it to 0, and `running_o` falls on that same edge.
- R6: Mode 1: after `rx_done_i`, the clock stops at the next toggle that drives it to 1.
- R7: Mode 3: after `tx_last_done_i`, the clock stops at the next toggle that drives it to 1. In this mode `rx_done_i` has no effect.
- R8: In modes 0 and 1, `tx_last_done_i` has no effect.
- R9: Mode 2: the clock never stops. Mode writes (`mode_we_i` with `mode_i`) are ignored until a reinit. A further `go_i` does not disturb the clock.
- R10: `reinit_i` forces `enc_clk_o` to 1, clears `running_o` and restores mode 1 on the next edge. It takes priority over a `go_i` or a mode write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Stop-policy value to load (0 stop low after rx, 1 stop high after rx, 2 free run, 3 stop high after tx) |
| mode_we_i | input | 1 | Loads `mode_i` into the mode register |
| go_i | input | 1 | Start strobe |
| reinit_i | input | 1 | Return to the default state |
| rx_done_i | input | 1 | Receiver has collected its frame |
| tx_last_done_i | input | 1 | Last transmit bit is on the wire |
| div_en_i | input | 1 | Divider count enable |
| enc_clk_o | output | 1 | Clock to the encoder |
| running_o | output | 1 | Clock active |

## Verification
Two events can land on the same edge: a stop request and a divider tick. The bench sweeps the arrival cycle of the stop source across two full output periods in each stopping mode, so the request meets every divider phase, including the tick edge itself. Each run is compared cycle by cycle against an arithmetic prediction of the stop edge, which is the first tick at or after the request that reaches the stop level. A second pair is a reinit in the same cycle as a go. The bench checks that the clock stays idle high.

// File: rtl/enc_clk_pkg.sv
package enc_clk_pkg;
  typedef enum logic [1:0] {
    CK_RX_LOW  = 2'd0,
    CK_RX_HIGH = 2'd1,
    CK_FREE    = 2'd2,
    CK_TX_HIGH = 2'd3
  } ckmode_e;
endpackage

// File: rtl/enc_clk_div.sv
module enc_clk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/enc_clk_mode.sv
module enc_clk_mode
  import enc_clk_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    reinit_i,
  input  logic    we_i,
  input  logic [1:0] val_i,
  output ckmode_e mode_o
);
  ckmode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        mode_q <= CK_RX_HIGH;
    else if (reinit_i)                  mode_q <= CK_RX_HIGH;
    else if (we_i && mode_q != CK_FREE) mode_q <= ckmode_e'(val_i);
  end

  assign mode_o = mode_q;

  AST_MODE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == CK_FREE && !reinit_i) |=> (mode_q == CK_FREE)); // R9
  AST_MODE_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (mode_q == CK_RX_HIGH)); // R10
endmodule

// File: rtl/enc_clk_gen.sv
module enc_clk_gen
  import enc_clk_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ckmode_e mode_i,
  input  logic    go_i,
  input  logic    reinit_i,
  input  logic    rx_done_i,
  input  logic    tx_last_done_i,
  input  logic    tick_i,
  output logic    clk_o,
  output logic    run_o
);
  logic run_q, clk_q, pend_q;
  logic stop_lvl, stop_src, pend_n, next_lvl;

  always_comb begin
    stop_lvl = (mode_i != CK_RX_LOW);
    unique case (mode_i)
      CK_RX_LOW, CK_RX_HIGH: stop_src = rx_done_i;
      CK_TX_HIGH:            stop_src = tx_last_done_i;
      default:               stop_src = 1'b0;
    endcase
    pend_n   = pend_q || stop_src;
    next_lvl = !clk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; clk_q <= 1'b1; pend_q <= 1'b0;
    end else if (reinit_i) begin
      run_q <= 1'b0; clk_q <= 1'b1; pend_q <= 1'b0;
    end else if (!run_q) begin
      if (go_i) begin
        run_q  <= 1'b1;
        pend_q <= 1'b0;
      end
    end else if (tick_i) begin
      clk_q <= next_lvl;
      if (pend_n && (next_lvl == stop_lvl)) begin
        run_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_n;
      end
    end else begin
      pend_q <= pend_n;
    end
  end

  assign clk_o = clk_q;
  assign run_o = run_q;

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !$past(run_q) && !$past(reinit_i)) |-> $stable(clk_q)); // R2
  AST_GO_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && go_i && !reinit_i) |=> run_q); // R3
  AST_EDGE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(clk_q) && !$past(reinit_i)) |-> $past(tick_i)); // R4
  AST_STOP_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(run_q) && !$past(reinit_i)) |-> (clk_q == ($past(mode_i) != CK_RX_LOW))); // R5
  AST_REINIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (clk_q && !run_q)); // R10
endmodule

// File: rtl/enc_clk_ctrl.sv
module enc_clk_ctrl
  import enc_clk_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       mode_we_i,
  input  logic       go_i,
  input  logic       reinit_i,
  input  logic       rx_done_i,
  input  logic       tx_last_done_i,
  input  logic       div_en_i,
  output logic       enc_clk_o,
  output logic       running_o
);
  ckmode_e mode_w;
  logic    tick_w, run_w;

  enc_clk_mode u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .reinit_i(reinit_i),
    .we_i(mode_we_i), .val_i(mode_i), .mode_o(mode_w)
  );

  enc_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!run_w || reinit_i),
    .en_i(div_en_i), .tick_o(tick_w)
  );

  enc_clk_gen u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_w), .go_i(go_i),
    .reinit_i(reinit_i), .rx_done_i(rx_done_i), .tx_last_done_i(tx_last_done_i),
    .tick_i(tick_w), .clk_o(enc_clk_o), .run_o(run_w)
  );

  assign running_o = run_w;
endmodule

// File: tb/enc_clk_ctrl_tb_top.sv
module enc_clk_ctrl_tb_top;
  localparam int H = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic mode_we = 0, go = 0, reinit = 0, rx_done = 0, tx_done = 0, div_en = 1;
  logic enc_clk, running;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  enc_clk_ctrl #(.HALF_DIV(H)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .mode_we_i(mode_we), .go_i(go),
    .reinit_i(reinit), .rx_done_i(rx_done), .tx_last_done_i(tx_done),
    .div_en_i(div_en), .enc_clk_o(enc_clk), .running_o(running)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reinit();
    reinit = 1; step(); reinit = 0;
  endtask

  // expected level at edge n after go (start high): toggles at multiples of H
  function automatic bit lvl_at(input int n);
    return ((n / H) % 2) == 0;
  endfunction

  task automatic run_case(input int m, input bit wr, input int rx_at, input int tx_at,
                          input int go2_at, input int wr_at, input int stop_at,
                          input bit stop_lvl, input string req);
    int kstop = 1 << 20;
    bit ok = 1;
    int bad_n = 0, act = 0, exp = 0;
    do_reinit();
    if (wr) begin mode = m[1:0]; mode_we = 1; step(); mode_we = 0; end
    if (stop_at >= 1) begin
      kstop = 1;
      while ((H * kstop < stop_at) || (((kstop % 2) == 0) != stop_lvl)) kstop++;
    end
    go = 1; step(); go = 0;
    for (int n = 1; n <= 48; n++) begin
      bit ec, er;
      rx_done = (n == rx_at); tx_done = (n == tx_at); go = (n == go2_at);
      mode_we = (n == wr_at); mode = 2'd0;
      step();
      if (n < H * kstop) begin ec = lvl_at(n); er = 1; end
      else begin ec = stop_lvl; er = 0; end
      if (ok && (enc_clk !== ec || running !== er)) begin
        ok = 0; bad_n = n; act = {enc_clk, running}; exp = {ec, er};
      end
    end
    rx_done = 0; tx_done = 0; go = 0; mode_we = 0;
    chk(ok, req, $sformatf("mode %0d stop_at %0d first bad cycle %0d {clk,run}", m, stop_at, bad_n), act, exp);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    // R1 reset state
    chk(enc_clk === 1'b1 && running === 1'b0, "R1", "reset {clk,run}", {enc_clk, running}, 2);
    // R2 idle: stimuli without go
    begin
      bit ok = 1;
      for (int i = 0; i < 20; i++) begin
        rx_done = i[0]; tx_done = i[1]; div_en = i[2];
        step();
        if (enc_clk !== 1'b1 || running !== 1'b0) ok = 0;
      end
      rx_done = 0; tx_done = 0; div_en = 1;
      chk(ok, "R2", "idle clock held high", enc_clk, 1);
    end
    // R1 default mode 1 (no write): stops high after rx_done; R3 start timing
    run_case(1, 0, 2, -1, -1, -1, 2, 1'b1, "R1 R3");
    // sweep stop arrival over two periods, every divider phase
    for (int d = 1; d <= 2 * 2 * H; d++) begin
      run_case(0, 1, d, -1, -1, -1, d, 1'b0, "R5");
      run_case(1, 1, d, -1, -1, -1, d, 1'b1, "R6");
      run_case(3, 1, -1, d, -1, -1, d, 1'b1, "R7");
    end
    // wrong source ignored
    run_case(0, 1, -1, 4, -1, -1, -1, 1'b0, "R8");
    run_case(1, 1, -1, 5, -1, -1, -1, 1'b1, "R8");
    run_case(3, 1, 4, -1, -1, -1, -1, 1'b1, "R7");
    // free run: no stop, second go, mode write ignored then rx_done
    run_case(2, 1, 7, 8, 5, 3, -1, 1'b1, "R9");
    run_case(2, 1, 10, 10, 4, 2, -1, 1'b1, "R9");
    // R10: reinit mid-run while low, restores mode 1
    do_reinit();
    mode = 2'd2; mode_we = 1; step(); mode_we = 0;
    go = 1; step(); go = 0;
    repeat (H) step();
    chk(enc_clk === 1'b0 && running === 1'b1, "R10", "low phase before reinit {clk,run}", {enc_clk, running}, 1);
    reinit = 1; go = 1; mode = 2'd0; mode_we = 1; step();
    reinit = 0; go = 0; mode_we = 0;
    chk(enc_clk === 1'b1 && running === 1'b0, "R10", "reinit wins over go/write {clk,run}", {enc_clk, running}, 2);
    run_case(1, 0, 3, -1, -1, -1, 3, 1'b1, "R10");
    // R4: divider enable low freezes the clock
    do_reinit();
    go = 1; step(); go = 0;
    div_en = 0; repeat (10) step();
    chk(enc_clk === 1'b1 && running === 1'b1, "R4", "frozen with div_en low {clk,run}", {enc_clk, running}, 3);
    div_en = 1; repeat (H - 1) step();
    chk(enc_clk === 1'b1, "R4", "no edge before full count", enc_clk, 1);
    step();
    chk(enc_clk === 1'b0, "R4", "edge after full count", enc_clk, 0);
    do_reinit();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule